// File: doc/BRIEF.md
# Option Serial Programming Register

This block holds the fourteen user option bits of a sensing controller and lets a tester load them over a two-wire serial path. A data level and a programming clock shift bits into a working shift register. A separate programming enable copies the whole shifted word into a holding register, which is modelled as flops. The holding register drives the decoded option fields. A serial read/write mode reloads the shift register from the holding register. In that mode the stored word moves out on a serial output, one bit per programming clock. New bits enter at the same time, so that mode can also write.

All inputs are synchronous to `clk`. The programming clock and enable are levels, and the block acts on their rising edges as seen at `clk`. A two-bit mode input selects the state machine path. The machine has four states: IDLE, PROG (option programming), LOAD (a one-cycle reload from storage) and READ (serial read/write). It has these transitions. IDLE goes to PROG on the programming mode and to LOAD on the read/write mode. PROG goes to LOAD on the read/write mode and to IDLE on the idle mode. LOAD goes to READ on the read/write mode, to PROG on the programming mode and to IDLE otherwise. READ goes to PROG on the programming mode and to IDLE on the idle mode. Mode code 3 counts as idle everywhere.

Top module: `opt_serial_prog`

## Requirements
- R1: After reset, every option field is 0 and `serial_o` is 0.
- R2: In programming mode (mode 1), each rising edge of `prog_clk_i` shifts the shift register left by one place. The value of `prog_data_i` enters at bit 0, and bit 13 is lost. The first bit shifted in therefore ends at bit 13 after fourteen edges.
- R3: The stored word w maps to the fields as follows. Gain is w[13:12], integration time w[11:10], emitter current w[9:8], low-battery trip w[7:5], drift compensation w[4], hush option w[3], low-battery hush w[2], end of life w[1] and tone w[0].
- R4: A rising edge of `prog_en_i` in programming or read/write mode copies all fourteen shift bits into storage, in the cycle after the edge is driven. Holding the enable high causes no further copies.
- R5: Shifting without a commit leaves every option field unchanged.
- R6: In idle mode (mode 0 or mode 3), programming clocks and enables have no effect on the option fields.
- R7: Two clock cycles after the mode becomes read/write (mode 2), `serial_o` shows stored bit 13. Each `prog_clk_i` rising edge then presents the next lower stored bit, MSB first.
- R8: In read/write mode, the bits clocked in on `prog_data_i` follow the stored bits out on `serial_o`. A commit there stores the shifted word.
- R9: When more than fourteen bits are shifted before a commit, only the last fourteen are kept.
- R10: `serial_o` is 0 whenever the mode was not read/write in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| mode_i | input | 2 | 0 idle, 1 programming, 2 read/write, 3 idle |
| prog_clk_i | input | 1 | Programming clock level; acts on its rising edge |
| prog_data_i | input | 1 | Serial data level |
| prog_en_i | input | 1 | Programming enable level; commits on its rising edge |
| serial_o | output | 1 | Serial readback bit |
| gain_o | output | 2 | Photo gain option |
| integ_o | output | 2 | Integration time option |
| emit_o | output | 2 | Emitter current option |
| lowbat_o | output | 3 | Low-battery trip option |
| drift_en_o | output | 1 | Drift compensation enable |
| hush_o | output | 1 | Hush option |
| lb_hush_o | output | 1 | Low-battery hush enable |
| eol_en_o | output | 1 | End-of-life enable |
| tone_o | output | 1 | Tone select |

## Verification
The assertions assume that `mode_i` is held steady while a programming clock or enable edge is processed. They also assume that no edge arrives during the one LOAD cycle that follows entry to read/write mode. The bench changes inputs only on falling clock edges. Each programming-clock or enable pulse lasts one full cycle. After every mode change the bench waits three cycles before pulsing anything, so every edge falls in a settled PROG, READ or IDLE state.

// File: rtl/opt_pkg.sv
package opt_pkg;
    localparam int WORD_W   = 14;
    localparam int MODE_W   = 2;

    localparam int GAIN_W   = 2;
    localparam int INTEG_W  = 2;
    localparam int EMIT_W   = 2;
    localparam int LOWBAT_W = 3;

    // fields packed MSB-first in shift order; each 1-bit flag follows
    localparam int TONE_LSB   = 0;
    localparam int EOL_LSB    = TONE_LSB + 1;
    localparam int LBH_LSB    = EOL_LSB + 1;
    localparam int HUSH_LSB   = LBH_LSB + 1;
    localparam int DRIFT_LSB  = HUSH_LSB + 1;
    localparam int LOWBAT_LSB = DRIFT_LSB + 1;
    localparam int EMIT_LSB   = LOWBAT_LSB + LOWBAT_W;
    localparam int INTEG_LSB  = EMIT_LSB + EMIT_W;
    localparam int GAIN_LSB   = INTEG_LSB + INTEG_W;

    localparam logic [MODE_W-1:0] MODE_IDLE = 2'd0;
    localparam logic [MODE_W-1:0] MODE_PROG = 2'd1;
    localparam logic [MODE_W-1:0] MODE_RW   = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_LOAD,
        ST_READ
    } opt_state_e;
endpackage

// File: rtl/opt_edge_det.sv
module opt_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/opt_shift_fsm.sv
module opt_shift_fsm
    import opt_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              shift_i,
    input  logic              data_i,
    input  logic              commit_req_i,
    input  logic [W-1:0]      store_word_i,
    output logic [W-1:0]      shreg_o,
    output logic              commit_o,
    output logic              serial_o
);
    opt_state_e state_q, state_d;
    logic [W-1:0] shreg_q;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_i == MODE_PROG)    state_d = ST_PROG;
                else if (mode_i == MODE_RW) state_d = ST_LOAD;
                else                        state_d = ST_IDLE;
            end
            ST_PROG: begin
                if (mode_i == MODE_PROG)    state_d = ST_PROG;
                else if (mode_i == MODE_RW) state_d = ST_LOAD;
                else                        state_d = ST_IDLE;
            end
            ST_LOAD: begin
                if (mode_i == MODE_RW)        state_d = ST_READ;
                else if (mode_i == MODE_PROG) state_d = ST_PROG;
                else                          state_d = ST_IDLE;
            end
            ST_READ: begin
                if (mode_i == MODE_RW)        state_d = ST_READ;
                else if (mode_i == MODE_PROG) state_d = ST_PROG;
                else                          state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOAD)
                shreg_q <= store_word_i;
            else if (shift_i && (state_q == ST_PROG || state_q == ST_READ))
                shreg_q <= {shreg_q[W-2:0], data_i};
        end
    end

    // output process
    always_comb begin
        commit_o = 1'b0;
        serial_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: ;
            ST_PROG: commit_o = commit_req_i;
            ST_READ: begin
                commit_o = commit_req_i;
                serial_o = shreg_q[W-1];
            end
        endcase
    end

    assign shreg_o = shreg_q;

    // R2: shifting moves left, data enters at bit 0
    a_r2_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && (state_q == ST_PROG || state_q == ST_READ))
        |=> (shreg_q == {$past(shreg_q[W-2:0]), $past(data_i)}));

    // R7: the reload cycle copies the stored word into the shift register
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (shreg_q == $past(store_word_i)));
endmodule

// File: rtl/opt_store.sv
module opt_store #(
    parameter int W = opt_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (commit_i) word_q <= word_i;
    end

    assign word_o = word_q;

    // R4 / R5: stored word only changes after a commit
    a_r4_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_q) |-> $past(commit_i));
endmodule

// File: rtl/opt_decode.sv
module opt_decode
    import opt_pkg::*;
(
    input  logic [WORD_W-1:0]   word_i,
    output logic [GAIN_W-1:0]   gain_o,
    output logic [INTEG_W-1:0]  integ_o,
    output logic [EMIT_W-1:0]   emit_o,
    output logic [LOWBAT_W-1:0] lowbat_o,
    output logic                drift_en_o,
    output logic                hush_o,
    output logic                lb_hush_o,
    output logic                eol_en_o,
    output logic                tone_o
);
    assign gain_o     = word_i[GAIN_LSB   +: GAIN_W];
    assign integ_o    = word_i[INTEG_LSB  +: INTEG_W];
    assign emit_o     = word_i[EMIT_LSB   +: EMIT_W];
    assign lowbat_o   = word_i[LOWBAT_LSB +: LOWBAT_W];
    assign drift_en_o = word_i[DRIFT_LSB];
    assign hush_o     = word_i[HUSH_LSB];
    assign lb_hush_o  = word_i[LBH_LSB];
    assign eol_en_o   = word_i[EOL_LSB];
    assign tone_o     = word_i[TONE_LSB];
endmodule

// File: rtl/opt_serial_prog.sv
module opt_serial_prog
    import opt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    input  logic        prog_clk_i,
    input  logic        prog_data_i,
    input  logic        prog_en_i,
    output logic        serial_o,
    output logic [1:0]  gain_o,
    output logic [1:0]  integ_o,
    output logic [1:0]  emit_o,
    output logic [2:0]  lowbat_o,
    output logic        drift_en_o,
    output logic        hush_o,
    output logic        lb_hush_o,
    output logic        eol_en_o,
    output logic        tone_o
);
    localparam int N_EDGE = 2;

    logic [N_EDGE-1:0] rise;
    logic [WORD_W-1:0] shreg, store_word;
    logic              commit;

    opt_edge_det #(.N(N_EDGE)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({prog_en_i, prog_clk_i}),
        .rise_o (rise)
    );

    opt_shift_fsm #(.W(WORD_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .shift_i      (rise[0]),
        .data_i       (prog_data_i),
        .commit_req_i (rise[1]),
        .store_word_i (store_word),
        .shreg_o      (shreg),
        .commit_o     (commit),
        .serial_o     (serial_o)
    );

    opt_store #(.W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (shreg),
        .word_o   (store_word)
    );

    opt_decode u_dec (
        .word_i     (store_word),
        .gain_o     (gain_o),
        .integ_o    (integ_o),
        .emit_o     (emit_o),
        .lowbat_o   (lowbat_o),
        .drift_en_o (drift_en_o),
        .hush_o     (hush_o),
        .lb_hush_o  (lb_hush_o),
        .eol_en_o   (eol_en_o),
        .tone_o     (tone_o)
    );

    logic idle_mode;
    assign idle_mode = (mode_i == MODE_IDLE) || (mode_i == 2'd3);

    // R10: serial output quiet unless read/write mode was selected
    a_r10_serial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) != MODE_RW) |-> !serial_o);

    // R6: idle mode never alters the option fields
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        idle_mode |=> ##1 $stable({gain_o, integ_o, emit_o, lowbat_o,
                                   drift_en_o, hush_o, lb_hush_o, eol_en_o, tone_o}));
endmodule

// File: tb/opt_serial_prog_tb.sv
module opt_serial_prog_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       pclk = 1'b0, pdata = 1'b0, pen = 1'b0;
    logic       sout;
    logic [1:0] gain, integ, emit;
    logic [2:0] lowbat;
    logic       drift, hush, lbh, eol, tone;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    opt_serial_prog u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .prog_clk_i(pclk),
        .prog_data_i(pdata), .prog_en_i(pen), .serial_o(sout),
        .gain_o(gain), .integ_o(integ), .emit_o(emit), .lowbat_o(lowbat),
        .drift_en_o(drift), .hush_o(hush), .lb_hush_o(lbh),
        .eol_en_o(eol), .tone_o(tone)
    );

    function automatic logic [13:0] fields_now();
        return {gain, integ, emit, lowbat, drift, hush, lbh, eol, tone};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // expected field values computed arithmetically from the word
    task automatic check_fields(string req, logic [13:0] w);
        check(req, {14'd0, gain},   (w >> 12) & 3);
        check(req, {14'd0, integ},  (w >> 10) & 3);
        check(req, {14'd0, emit},   (w >> 8) & 3);
        check(req, {13'd0, lowbat}, (w >> 5) & 7);
        check(req, {11'd0, drift, hush, lbh, eol, tone}, w & 16'h1F);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(logic [1:0] m);
        mode = m;
        cyc(3);
    endtask

    task automatic pulse_clk(logic d);
        pdata = d; pclk = 1'b1; cyc(1);
        pclk = 1'b0; cyc(1);
    endtask

    task automatic shift_word(logic [13:0] w);
        for (int i = 13; i >= 0; i--) pulse_clk(w[i]);
    endtask

    task automatic commit();
        pen = 1'b1; cyc(1);
        pen = 1'b0; cyc(1);
    endtask

    task automatic program_word(logic [13:0] w);
        set_mode(2'd1);
        shift_word(w);
        commit();
    endtask

    // R7 readback: serial shows stored bits MSB first
    task automatic read_back(logic [13:0] w);
        mode = 2'd2;
        cyc(2);
        check("R7 first bit", {15'd0, sout}, {15'd0, w[13]});
        cyc(1);
        for (int j = 13; j >= 0; j--) begin
            check("R7 readback", {15'd0, sout}, {15'd0, w[j]});
            pulse_clk(1'b0);
        end
    endtask

    initial begin
        logic [13:0] w, v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 fields", {2'd0, fields_now()}, 16'd0);
        check("R1 serial", {15'd0, sout}, 16'd0);

        // R2 R3 walking ones, then a pseudo-random sweep
        for (int k = 0; k < 14; k++) begin
            w = 14'(1 << k);
            program_word(w);
            check_fields("R3 walk", w);
            read_back(w);
            set_mode(2'd0);
            check("R10 quiet", {15'd0, sout}, 16'd0);
        end
        for (int k = 0; k < 40; k++) begin
            w = 14'((k * 11213 + 77) & 16'h3FFF);
            program_word(w);
            check_fields("R2 sweep", w);
            read_back(w);
        end
        w = 14'h2D6B;
        program_word(w);
        check_fields("R2 base", w);

        // R5 shifting without commit
        shift_word(~w);
        check_fields("R5 no commit", w);
        check("R10 prog mode", {15'd0, sout}, 16'd0);

        // R4 held enable does not recommit
        v = 14'h1357;
        shift_word(v);
        pen = 1'b1; cyc(1);
        check_fields("R4 commit", v);
        shift_word(14'h3FFF);
        check_fields("R4 held", v);
        pen = 1'b0; cyc(1);
        commit();
        check_fields("R4 recommit", 14'h3FFF);

        // R9 extra bits: only last 14 kept
        shift_word(14'h0000);
        pulse_clk(1'b1); pulse_clk(1'b0); pulse_clk(1'b1);
        commit();
        check_fields("R9 overflow", 14'h0005);

        // R6 idle mode ignores clocks and enables (mode 0 and 3)
        set_mode(2'd0);
        shift_word(14'h2AAA); commit();
        check_fields("R6 idle0", 14'h0005);
        set_mode(2'd3);
        shift_word(14'h1555); commit();
        check_fields("R6 idle3", 14'h0005);
        check("R10 mode3", {15'd0, sout}, 16'd0);
        set_mode(2'd0);

        // R8 read/write: new bits follow, commit stores them
        w = 14'h0005;
        v = 14'h3A1C;
        mode = 2'd2; cyc(3);
        for (int j = 13; j >= 0; j--) begin
            check("R8 old out", {15'd0, sout}, {15'd0, w[j]});
            pulse_clk(v[j]);
        end
        for (int j = 13; j >= 0; j--) begin
            check("R8 new out", {15'd0, sout}, {15'd0, v[j]});
            pulse_clk(v[j]);
        end
        commit();
        check_fields("R8 rw commit", v);
        read_back(v);
        set_mode(2'd0);
        check("R10 after rw", {15'd0, sout}, 16'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual timeout expected done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule